// File: doc/BRIEF.md
# Dual-CPU Interrupt Mask Router

The router takes two 64-bit vectors of pending interrupt sources and turns them into interrupt lines for two processors. Each processor has two interrupt lines, one at level 2 and one at level 3. Each processor also has its own pair of mask registers, one for each vector. Vector 0 feeds level 2 only. The upper half of vector 1 always feeds level 3. The lower half of vector 1 is split into four byte groups, and a shared steering register sends each group to level 2 or to level 3.

The same steering register holds an enable for a single error-forward line. When this enable is set, the line asserts whenever one of a fixed set of memory, page-migration and fabric error sources is pending. The CPU masks play no part in this line. A small write/read port loads and reads back the masks and the steering register. Every output is registered.

Top module: `irq_mask_router`

## Requirements
- R1: After reset all four mask registers and the steering register read zero, and every interrupt output is low.
- R2: A CPU's level-2 output is high when some bit is set in both vector 0 and that CPU's vector-0 mask. Bit 3 of vector 0 is page migration.
- R3: A CPU's level-3 output is high when some bit in positions 63:32 is set in both vector 1 and that CPU's vector-1 mask.
- R4: Steering bit k (k = 0..3) controls vector-1 bits [8k+7:8k]. When it is 1, a masked-in set bit in that byte drives level 2. When it is 0, the bit drives level 3.
- R5: The error-forward output is high when steering bit 4 is 1 and any of these is set: vector-0 bit 3 (page migration), or vector-1 bits 36 (correctable memory), 37 (uncorrectable memory), 38 (network), 39 (local block) or 40 (crossbar).
- R6: The error-forward output does not depend on either CPU's masks.
- R7: Register addresses are 0 = CPU A vector-0 mask, 1 = CPU A vector-1 mask, 2 = CPU B vector-0 mask, 3 = CPU B vector-1 mask, 4 = steering. Read data is combinational from `reg_addr`. A write takes effect at the clock edge where `reg_we` is high.
- R8: Steering register bits 63:5 read back zero, and writes to them are ignored. Addresses 5 to 7 read zero, and writes to them change nothing.
- R9: Outputs are registered. A change on the pending inputs or in a register shows at the outputs one clock edge later.
- R10: The masks of one CPU have no effect on the outputs of the other CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend0_i | input | 64 | Pending vector 0 |
| pend1_i | input | 64 | Pending vector 1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| cpu_a_l2 | output | 1 | CPU A level-2 interrupt |
| cpu_a_l3 | output | 1 | CPU A level-3 interrupt |
| cpu_b_l2 | output | 1 | CPU B level-2 interrupt |
| cpu_b_l3 | output | 1 | CPU B level-3 interrupt |
| err_fwd | output | 1 | Error-forward request |

## Verification
A wrong mask or steering bit has two visible effects. It shows at once on `reg_rdata` when that address is read. It also shows on an interrupt line one edge after a pending bit falls in the affected position. The bench drives sparse random pending patterns together with random register writes. It compares every output against a behavioural model on every cycle, so a fault becomes visible within a cycle of the first stimulus that touches it. Directed phases cover each steering byte, the independence of the forward line from the masks, the isolation between the two CPUs, and the one-cycle latency.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    localparam int VEC_W   = 64;
    localparam int LO_W    = 32;
    localparam int REMAP_N = 4;
    localparam int ADDR_W  = 3;
    localparam int N_CPU   = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_M0_A  = 3'd0,
        RA_M1_A  = 3'd1,
        RA_M0_B  = 3'd2,
        RA_M1_B  = 3'd3,
        RA_STEER = 3'd4
    } reg_addr_e;

    // error sources selected for forwarding
    localparam logic [VEC_W-1:0] ERR0_SEL = 64'h0000_0000_0000_0008;
    localparam logic [VEC_W-1:0] ERR1_SEL = 64'h0000_01F0_0000_0000;
endpackage

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
    import irq_route_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int RN = REMAP_N,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [VW-1:0] wdata,
    output logic [VW-1:0] rdata,
    output logic [VW-1:0] mask0_a,
    output logic [VW-1:0] mask1_a,
    output logic [VW-1:0] mask0_b,
    output logic [VW-1:0] mask1_b,
    output logic [RN-1:0] steer,
    output logic          fwd_en
);
    localparam int SW = RN + 1;

    logic [VW-1:0] m0a_q, m1a_q, m0b_q, m1b_q;
    logic [SW-1:0] steer_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m0a_q   <= '0;
            m1a_q   <= '0;
            m0b_q   <= '0;
            m1b_q   <= '0;
            steer_q <= '0;
        end else if (we) begin
            unique case (addr)
                RA_M0_A:  m0a_q   <= wdata;
                RA_M1_A:  m1a_q   <= wdata;
                RA_M0_B:  m0b_q   <= wdata;
                RA_M1_B:  m1b_q   <= wdata;
                RA_STEER: steer_q <= wdata[SW-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_M0_A:  rdata = m0a_q;
            RA_M1_A:  rdata = m1a_q;
            RA_M0_B:  rdata = m0b_q;
            RA_M1_B:  rdata = m1b_q;
            RA_STEER: rdata[SW-1:0] = steer_q;
            default:  rdata = '0;
        endcase
    end

    assign mask0_a = m0a_q;
    assign mask1_a = m1a_q;
    assign mask0_b = m0b_q;
    assign mask1_b = m1b_q;
    assign steer   = steer_q[RN-1:0];
    assign fwd_en  = steer_q[RN];

    AST_STEER_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == RA_STEER) |-> (rdata[VW-1:SW] == '0)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_M0_A) |=> (mask0_a == $past(wdata))); // R7
endmodule

// File: rtl/irq_level_route.sv
`timescale 1ns/1ps
module irq_level_route
    import irq_route_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int LW = LO_W,
    parameter int RN = REMAP_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] pend0,
    input  logic [VW-1:0] pend1,
    input  logic [VW-1:0] mask0,
    input  logic [VW-1:0] mask1,
    input  logic [RN-1:0] steer,
    output logic          l2_o,
    output logic          l3_o
);
    localparam int GW = LW / RN;

    logic [LW-1:0] to_l2;
    logic [VW-1:0] hit1;
    logic          l2_d, l3_d, l2_q, l3_q;

    assign hit1 = pend1 & mask1;

    for (genvar g = 0; g < RN; g++) begin : g_grp
        assign to_l2[g*GW +: GW] = {GW{steer[g]}};

        AST_GRP_TO_L2: assert property (@(posedge clk) disable iff (!rst_n)
            (steer[g] && |hit1[g*GW +: GW]) |=> l2_o); // R4
        AST_GRP_TO_L3: assert property (@(posedge clk) disable iff (!rst_n)
            (!steer[g] && |hit1[g*GW +: GW]) |=> l3_o); // R4
    end

    always_comb begin
        l2_d = (|(pend0 & mask0)) | (|(hit1[LW-1:0] & to_l2));
        l3_d = (|hit1[VW-1:LW])   | (|(hit1[LW-1:0] & ~to_l2));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2_q <= 1'b0;
            l3_q <= 1'b0;
        end else begin
            l2_q <= l2_d;
            l3_q <= l3_d;
        end
    end

    assign l2_o = l2_q;
    assign l3_o = l3_q;

    AST_V0_TO_L2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend0 & mask0)) |=> l2_o); // R2
    AST_HI_TO_L3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend1[VW-1:LW] & mask1[VW-1:LW])) |=> l3_o); // R3
endmodule

// File: rtl/irq_err_fwd.sv
`timescale 1ns/1ps
module irq_err_fwd
    import irq_route_pkg::*;
#(
    parameter int               VW   = VEC_W,
    parameter logic [VW-1:0]    SEL0 = ERR0_SEL,
    parameter logic [VW-1:0]    SEL1 = ERR1_SEL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [VW-1:0] pend0,
    input  logic [VW-1:0] pend1,
    output logic          err_o
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= en & ((|(pend0 & SEL0)) | (|(pend1 & SEL1)));
    end

    assign err_o = err_q;

    AST_FWD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !err_o); // R5
    AST_FWD_PAGE_MIG: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pend0[3]) |=> err_o); // R5
endmodule

// File: rtl/irq_mask_router.sv
`timescale 1ns/1ps
module irq_mask_router
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  pend0_i,
    input  logic [VEC_W-1:0]  pend1_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [VEC_W-1:0]  reg_rdata,
    output logic              cpu_a_l2,
    output logic              cpu_a_l3,
    output logic              cpu_b_l2,
    output logic              cpu_b_l3,
    output logic              err_fwd
);
    logic [VEC_W-1:0]   m0 [N_CPU];
    logic [VEC_W-1:0]   m1 [N_CPU];
    logic [REMAP_N-1:0] steer;
    logic               fwd_en;
    logic [N_CPU-1:0]   l2, l3;

    irq_regs #(.VW(VEC_W), .RN(REMAP_N), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .mask0_a (m0[0]),
        .mask1_a (m1[0]),
        .mask0_b (m0[1]),
        .mask1_b (m1[1]),
        .steer   (steer),
        .fwd_en  (fwd_en)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        irq_level_route #(.VW(VEC_W), .LW(LO_W), .RN(REMAP_N)) u_route (
            .clk   (clk),
            .rst_n (rst_n),
            .pend0 (pend0_i),
            .pend1 (pend1_i),
            .mask0 (m0[c]),
            .mask1 (m1[c]),
            .steer (steer),
            .l2_o  (l2[c]),
            .l3_o  (l3[c])
        );
    end

    irq_err_fwd #(.VW(VEC_W), .SEL0(ERR0_SEL), .SEL1(ERR1_SEL)) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fwd_en),
        .pend0 (pend0_i),
        .pend1 (pend1_i),
        .err_o (err_fwd)
    );

    assign cpu_a_l2 = l2[0];
    assign cpu_a_l3 = l3[0];
    assign cpu_b_l2 = l2[1];
    assign cpu_b_l3 = l3[1];

    AST_B_SILENT_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (m0[1] == '0 && m1[1] == '0) |=> (!cpu_b_l2 && !cpu_b_l3)); // R10
endmodule

// File: tb/test_irq_mask_router.sv
`timescale 1ns/1ps
module test_irq_mask_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pend0 = '0, pend1 = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        a_l2, a_l3, b_l2, b_l3, efw;

    int checks = 0;
    int errors = 0;
    bit run_cmp = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_router i_irq_mask_router (
        .clk(clk), .rst_n(rst_n), .pend0_i(pend0), .pend1_i(pend1),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .cpu_a_l2(a_l2), .cpu_a_l3(a_l3), .cpu_b_l2(b_l2), .cpu_b_l3(b_l3),
        .err_fwd(efw));

    // behavioural model
    logic [63:0] bm [5];
    logic e_al2, e_al3, e_bl2, e_bl3, e_err;

    function automatic logic f_l2(logic [63:0] m0, logic [63:0] m1, logic [63:0] st,
                                  logic [63:0] p0, logic [63:0] p1);
        logic r = 1'b0;
        for (int i = 0; i < 64; i++) if (p0[i] && m0[i]) r = 1'b1;
        for (int i = 0; i < 32; i++) if (p1[i] && m1[i] && st[i/8]) r = 1'b1;
        return r;
    endfunction

    function automatic logic f_l3(logic [63:0] m1, logic [63:0] st, logic [63:0] p1);
        logic r = 1'b0;
        for (int i = 0; i < 64; i++)
            if (p1[i] && m1[i] && (i >= 32 || !st[i/8])) r = 1'b1;
        return r;
    endfunction

    function automatic logic f_err(logic [63:0] st, logic [63:0] p0, logic [63:0] p1);
        logic hit = p0[3];
        for (int i = 36; i <= 40; i++) if (p1[i]) hit = 1'b1;
        return st[4] && hit;
    endfunction

    function automatic logic [63:0] f_rd(logic [2:0] a);
        return (a < 3'd5) ? bm[a] : 64'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) bm[i] <= '0;
            {e_al2, e_al3, e_bl2, e_bl3, e_err} <= '0;
        end else begin
            e_al2 <= f_l2(bm[0], bm[1], bm[4], pend0, pend1);
            e_al3 <= f_l3(bm[1], bm[4], pend1);
            e_bl2 <= f_l2(bm[2], bm[3], bm[4], pend0, pend1);
            e_bl3 <= f_l3(bm[3], bm[4], pend1);
            e_err <= f_err(bm[4], pend0, pend1);
            if (we && addr < 3'd4) bm[addr] <= wdata;
            else if (we && addr == 3'd4) bm[4] <= {59'h0, wdata[4:0]};
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            chk("R2 cpu_a_l2", 64'(a_l2), 64'(e_al2));
            chk("R3 cpu_a_l3", 64'(a_l3), 64'(e_al3));
            chk("R10 cpu_b_l2", 64'(b_l2), 64'(e_bl2));
            chk("R4 cpu_b_l3", 64'(b_l3), 64'(e_bl3));
            chk("R5 err_fwd", 64'(efw), 64'(e_err));
            chk("R7 reg_rdata", rdata, f_rd(addr));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [2:0] a, logic [63:0] d);
        we = 1'b1; addr = a; wdata = d;
        step();
        we = 1'b0;
    endtask

    task automatic clr_all();
        for (int a = 0; a < 5; a++) wr(3'(a), 64'h0);
        pend0 = '0; pend1 = '0;
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 outputs", 64'({a_l2, a_l3, b_l2, b_l3, efw}), 64'h0);
        for (int a = 0; a < 5; a++) begin
            addr = 3'(a); #0.1;
            chk("R1 reg readback", rdata, 64'h0);
        end
        step();
        run_cmp = 1'b1;

        // R8: reserved steering bits and unused addresses
        wr(3'd4, '1);
        addr = 3'd4; #0.1;
        chk("R8 steer readback", rdata, 64'h1F);
        wr(3'd6, '1);
        addr = 3'd6; #0.1;
        chk("R8 unused addr", rdata, 64'h0);
        addr = 3'd0; #0.1;
        chk("R8 unused write no effect", rdata, 64'h0);
        clr_all();

        // R6: forward line ignores masks
        wr(3'd4, 64'h10);
        pend1 = 64'h1 << 38;
        step();
        @(negedge clk);
        chk("R6 forward with masks clear", 64'(efw), 64'h1);
        chk("R6 no cpu line", 64'({a_l2, a_l3, b_l2, b_l3}), 64'h0);
        clr_all();

        // R10: CPU A mask only
        wr(3'd0, '1);
        pend0 = 64'h10;
        step();
        @(negedge clk);
        chk("R10 cpu A raised", 64'(a_l2), 64'h1);
        chk("R10 cpu B quiet", 64'({b_l2, b_l3}), 64'h0);
        clr_all();

        // R4: each steering byte, both settings
        wr(3'd1, '1);
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 2; s++) begin
                wr(3'd4, 64'(s) << k);
                pend1 = 64'h1 << (8 * k + 5);
                step();
                @(negedge clk);
                chk("R4 byte to l2", 64'(a_l2), 64'(s));
                chk("R4 byte to l3", 64'(a_l3), 64'(1 - s));
                pend1 = '0;
                step();
            end
        end
        clr_all();

        // R9: one-cycle latency
        wr(3'd3, '1);
        step();
        pend1 = 64'h1 << 50;
        @(negedge clk);
        chk("R9 not yet", 64'(b_l3), 64'h0);
        @(negedge clk);
        chk("R9 after one edge", 64'(b_l3), 64'h1);
        clr_all();

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            we    = ($urandom_range(0, 3) == 0);
            addr  = 3'($urandom_range(0, 7));
            wdata = {$urandom, $urandom} & {$urandom, $urandom};
            pend0 = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            pend1 = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) pend0 = '0;
            if ($urandom_range(0, 3) == 0) pend1 = '0;
            step();
        end
        we = 1'b0;
        step();
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule